// File: doc/BRIEF.md
# Hierarchical Page Table Walker

This block turns a 64-bit linear address into a physical address. It walks a radix tree of page-sized mapping tables held in memory. The walk starts at the table whose base is given by a root-pointer input. Each level uses one slice of the address as an index into the current table. That slice is 9 bits wide, except at the top level, where it may be narrower. The entry found at that index gives the base of the next table, or of the final page.

The walker takes one request at a time. It first checks that the address is canonical. It then issues one entry read per level on a single-outstanding memory port. It finishes with a one-cycle `done_o` pulse. That pulse carries either the physical address or a fault code and the level where the walk stopped.

The implemented address width is a parameter, and the number of levels is derived from it.

Top module: `ptw_walker`

## Requirements
- R1: An address is canonical when bits 63 down to ADDR_W-1 are all equal. A request with a non-canonical address issues no memory read. It yields `done_o` in the cycle after acceptance, with `fault_code_o` = 1.
- R2: The level count is ceil((ADDR_W-12)/9). A walk that reaches the page issues exactly that many reads.
- R3: The read for level n goes to the level-n table base plus eight times the level-n index. Indices are taken from the most significant field (level 0) down to the field just above bit 12. Each field below the top one is 9 bits wide, and read addresses are 8-byte aligned.
- R4: The top field is bits ADDR_W-1 down to 12+9*(levels-1) and may be narrower than 9 bits. It is zero-extended, so sign bits above ADDR_W-1 never reach the index.
- R5: An entry is present when its bit 0 is 1. An entry with bit 0 clear ends the walk at once, with `fault_code_o` = 2 and `fault_level_o` set to that level. No further read is issued.
- R6: Entry bits 51:12 give the next base. On success, `paddr_o` is the last entry's base concatenated with address bits 11:0, and `fault_code_o` = 0.
- R7: `mem_req_o` is high for one cycle per read. No new read is issued until `mem_rvalid_i` has returned the previous one.
- R8: `req_ready_o` is high only when idle. A request presented while busy is ignored and starts no walk.
- R9: `done_o` is high for exactly one cycle per accepted request.
- R10: The root pointer is sampled when a request is accepted. A change during a walk affects only later requests.
- R11: After reset, `req_ready_o` is high and both `done_o` and `mem_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| root_ptr_i | input | PA_W | Physical address of the level-0 table (bits 11:0 ignored) |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Walker idle, request accepted when valid |
| req_vaddr_i | input | 64 | Linear address to translate |
| mem_req_o | output | 1 | Entry read strobe (one cycle) |
| mem_addr_o | output | PA_W | Entry physical address |
| mem_rvalid_i | input | 1 | Entry data valid |
| mem_rdata_i | input | 64 | Entry data |
| done_o | output | 1 | Walk finished (one cycle) |
| fault_o | output | 1 | Walk finished with a fault |
| fault_code_o | output | 2 | 0 none, 1 non-canonical, 2 entry not present |
| fault_level_o | output | LVL_W | Level of the absent entry |
| paddr_o | output | PA_W | Translated physical address |

## Verification
The bench uses a 44-bit configuration, which has four levels and a 5-bit top field.

High-half addresses check that the top index is not polluted by sign bits; a walker that sign-extended or took 9 bits there would read the wrong level-0 entry. Addresses just inside and just outside the canonical range catch an off-by-one in the checked bit span. Missing entries are placed at the first, a middle and the last level; a walker that kept going would issue extra reads, and one that mislabelled the level would report the wrong stop point. The root is changed mid-walk, and a request is pushed while busy, to expose a live root or a second walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {
    FLT_NONE     = 2'd0,
    FLT_NONCANON = 2'd1,
    FLT_ABSENT   = 2'd2
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_RESP
  } state_e;

  localparam int unsigned PG_SHIFT = 12;
  localparam int unsigned IDX_W    = 9;

  function automatic int unsigned lvl_count(input int unsigned k);
    return (k - PG_SHIFT + IDX_W - 1) / IDX_W;
  endfunction
endpackage

// File: rtl/ptw_canon_chk.sv
module ptw_canon_chk #(
  parameter int unsigned VA_W   = 64,
  parameter int unsigned ADDR_W = 48
) (
  input  logic [VA_W-1:0] vaddr_i,
  output logic            canon_o
);
  localparam int unsigned HI_W = VA_W - ADDR_W + 1;

  logic [HI_W-1:0] hi;
  assign hi      = vaddr_i[VA_W-1:ADDR_W-1];
  assign canon_o = (&hi) | ~(|hi);
endmodule

// File: rtl/ptw_idx_sel.sv
module ptw_idx_sel #(
  parameter int unsigned VA_W   = 64,
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned LEVELS = 4,
  parameter int unsigned LVL_W  = 2
) (
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic [8:0]       idx_o
);
  import ptw_pkg::*;
  localparam int unsigned TOP_W = ADDR_W - PG_SHIFT - IDX_W * (LEVELS - 1);

  logic [8:0] fld [LEVELS];

  for (genvar l = 0; l < LEVELS; l++) begin : g_fld
    localparam int unsigned LSB = PG_SHIFT + IDX_W * (LEVELS - 1 - l);
    if (l == 0 && TOP_W < IDX_W) begin : g_top_narrow
      assign fld[l] = {{(IDX_W - TOP_W){1'b0}}, vaddr_i[LSB+TOP_W-1:LSB]};
    end else begin : g_full
      assign fld[l] = vaddr_i[LSB+IDX_W-1:LSB];
    end
  end

  always_comb begin
    idx_o = '0;
    for (int l = 0; l < LEVELS; l++) begin
      if (lvl_i == LVL_W'(l)) idx_o = fld[l];
    end
  end
endmodule

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
  parameter int unsigned PA_W = 52
) (
  input  logic [PA_W-13:0] base_i,
  input  logic [8:0]       idx_i,
  output logic [PA_W-1:0]  addr_o
);
  // base is page aligned, so base + idx*8 is a plain concatenation
  assign addr_o = {base_i, idx_i, 3'b000};
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned PA_W   = 52,
  localparam int unsigned LEVELS = ptw_pkg::lvl_count(ADDR_W),
  localparam int unsigned LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PA_W-1:0]  root_ptr_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [63:0]      req_vaddr_i,
  output logic             mem_req_o,
  output logic [PA_W-1:0]  mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [63:0]      mem_rdata_i,
  output logic             done_o,
  output logic             fault_o,
  output logic [1:0]       fault_code_o,
  output logic [LVL_W-1:0] fault_level_o,
  output logic [PA_W-1:0]  paddr_o
);
  import ptw_pkg::*;
  localparam int unsigned VA_W   = 64;
  localparam int unsigned BASE_W = PA_W - PG_SHIFT;
  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

  state_e            state_q;
  logic [VA_W-1:0]   vaddr_q;
  logic [BASE_W-1:0] base_q;
  logic [LVL_W-1:0]  lvl_q;
  fault_e            code_q;
  logic [LVL_W-1:0]  flvl_q;
  logic [PA_W-1:0]   paddr_q;

  logic       canon;
  logic [8:0] idx;
  logic       entry_ok;

  ptw_canon_chk #(.VA_W(VA_W), .ADDR_W(ADDR_W)) u_canon (
    .vaddr_i (req_vaddr_i),
    .canon_o (canon)
  );

  ptw_idx_sel #(.VA_W(VA_W), .ADDR_W(ADDR_W), .LEVELS(LEVELS), .LVL_W(LVL_W)) u_idx (
    .vaddr_i (vaddr_q),
    .lvl_i   (lvl_q),
    .idx_o   (idx)
  );

  ptw_entry_addr #(.PA_W(PA_W)) u_eaddr (
    .base_i (base_q),
    .idx_i  (idx),
    .addr_o (mem_addr_o)
  );

  assign entry_ok = mem_rdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      vaddr_q <= '0;
      base_q  <= '0;
      lvl_q   <= '0;
      code_q  <= FLT_NONE;
      flvl_q  <= '0;
      paddr_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            vaddr_q <= req_vaddr_i;
            base_q  <= root_ptr_i[PA_W-1:PG_SHIFT];
            lvl_q   <= '0;
            flvl_q  <= '0;
            paddr_q <= '0;
            if (!canon) begin
              code_q  <= FLT_NONCANON;
              state_q <= ST_RESP;
            end else begin
              code_q  <= FLT_NONE;
              state_q <= ST_ISSUE;
            end
          end
        end
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (mem_rvalid_i) begin
            if (!entry_ok) begin
              code_q  <= FLT_ABSENT;
              flvl_q  <= lvl_q;
              state_q <= ST_RESP;
            end else begin
              base_q <= mem_rdata_i[PA_W-1:PG_SHIFT];
              if (lvl_q == LAST_LVL) begin
                paddr_q <= {mem_rdata_i[PA_W-1:PG_SHIFT], vaddr_q[PG_SHIFT-1:0]};
                state_q <= ST_RESP;
              end else begin
                lvl_q   <= lvl_q + 1'b1;
                state_q <= ST_ISSUE;
              end
            end
          end
        end
        ST_RESP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o   = (state_q == ST_IDLE);
  assign mem_req_o     = (state_q == ST_ISSUE);
  assign done_o        = (state_q == ST_RESP);
  assign fault_code_o  = code_q;
  assign fault_o       = done_o && (code_q != FLT_NONE);
  assign fault_level_o = flvl_q;
  assign paddr_o       = paddr_q;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned PA_W   = 52
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [PA_W-1:0] root_ptr_i,
  input logic            req_valid_i,
  input logic            req_ready_o,
  input logic [63:0]     req_vaddr_i,
  input logic            mem_req_o,
  input logic [PA_W-1:0] mem_addr_o,
  input logic            mem_rvalid_i,
  input logic [63:0]     mem_rdata_i,
  input logic            done_o,
  input logic [1:0]      fault_code_o
);
  logic accept, hi_same, pend_q;

  assign accept  = req_valid_i && req_ready_o;
  assign hi_same = (&req_vaddr_i[63:ADDR_W-1]) || !(|req_vaddr_i[63:ADDR_W-1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           pend_q <= 1'b0;
    else if (mem_req_o)    pend_q <= 1'b1;
    else if (mem_rvalid_i) pend_q <= 1'b0;
  end

  assert_noncanon_fault_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !hi_same |=> done_o && fault_code_o == 2'd1 && !mem_req_o);

  assert_entry_aligned_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[2:0] == 3'b000);

  assert_absent_stop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && mem_rvalid_i && !mem_rdata_i[0] |=> done_o && fault_code_o == 2'd2 && !mem_req_o);

  assert_read_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  assert_single_outstanding_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !pend_q);

  assert_busy_not_ready_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o || pend_q) |-> !req_ready_o);

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_root_sampled_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && hi_same |=> mem_req_o && mem_addr_o[PA_W-1:12] == $past(root_ptr_i[PA_W-1:12]));
endmodule

bind ptw_walker ptw_walker_chk #(.ADDR_W(ADDR_W), .PA_W(PA_W)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .root_ptr_i   (root_ptr_i),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .req_vaddr_i  (req_vaddr_i),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .mem_rvalid_i (mem_rvalid_i),
  .mem_rdata_i  (mem_rdata_i),
  .done_o       (done_o),
  .fault_code_o (fault_code_o)
);

// File: tb/ptw_walker_tb_top.sv
module ptw_walker_tb_top;
  localparam int K    = 44;
  localparam int PA   = 52;
  localparam int LV   = 4;                     // ceil((44-12)/9)
  localparam logic [63:0] TOPMASK = 64'h1F;    // 5-bit top field, bits 43:39

  typedef struct packed {
    logic [63:0] va;
    logic [51:0] root;
    logic [1:0]  code;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{64'h0000_0123_4567_89AB, 52'h0_0001_2345_6000, 2'd0},
    '{64'hFFFF_F812_3456_7ABC, 52'h0_0001_2345_6000, 2'd0},
    '{64'h0000_07FF_FFFF_FFFF, 52'h0_00AB_CDE0_1000, 2'd0},
    '{64'hFFFF_F800_0000_0000, 52'h0_00AB_CDE0_1000, 2'd0},
    '{64'h0000_0000_0000_0FFF, 52'h0_0000_0000_0000, 2'd0},
    '{64'h0000_0800_0000_0000, 52'h0_0001_2345_6000, 2'd1},
    '{64'hFFFF_F000_0000_0000, 52'h0_0001_2345_6000, 2'd1},
    '{64'h8000_0000_0000_1000, 52'h0_0001_2345_6000, 2'd1}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [51:0] root_ptr_i = '0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [63:0] req_vaddr_i = '0;
  logic        mem_req_o;
  logic [51:0] mem_addr_o;
  logic        mem_rvalid_i = 1'b0;
  logic [63:0] mem_rdata_i = '0;
  logic        done_o;
  logic        fault_o;
  logic [1:0]  fault_code_o;
  logic [1:0]  fault_level_o;
  logic [51:0] paddr_o;

  always #2 clk_i = ~clk_i;

  ptw_walker #(.ADDR_W(K), .PA_W(PA)) dut_i (
    .clk_i, .rst_ni, .root_ptr_i, .req_valid_i, .req_ready_o, .req_vaddr_i,
    .mem_req_o, .mem_addr_o, .mem_rvalid_i, .mem_rdata_i,
    .done_o, .fault_o, .fault_code_o, .fault_level_o, .paddr_o
  );

  int n_chk = 0;
  int n_bad = 0;

  // memory model and expectations
  logic        hole_on = 1'b0;
  logic [51:0] hole_a  = '0;
  logic [51:0] e_addr [LV];
  logic [51:0] e_pa;
  int          e_code, e_lvl, e_n;
  int          rd_n = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] ent(input logic [51:0] a);
    logic [39:0] nb;
    nb = a[42:3] ^ 40'h35_9C2E_71A4 ^ {a[21:3], 21'h0};
    return {12'h0, nb, 11'h0, !(hole_on && a == hole_a)};
  endfunction

  task automatic predict(input logic [63:0] va, input logic [51:0] root);
    logic [39:0] b;
    logic [63:0] idx, d;
    e_code = 0; e_lvl = 0; e_n = 0; e_pa = '0;
    if (!((&va[63:K-1]) || !(|va[63:K-1]))) begin
      e_code = 1;
      return;
    end
    b = root[51:12];
    for (int l = 0; l < LV; l++) begin
      idx = (va >> (12 + 9 * (LV - 1 - l))) & ((l == 0) ? TOPMASK : 64'h1FF);
      e_addr[l] = {b, 12'h000} + 52'(idx * 8);
      e_n = l + 1;
      d = ent(e_addr[l]);
      if (!d[0]) begin
        e_code = 2;
        e_lvl = l;
        return;
      end
      b = d[51:12];
    end
    e_pa = {b, va[11:0]};
  endtask

  int          pend = 0;
  int          lat_cnt = 0;
  logic [51:0] pend_a = '0;

  always @(negedge clk_i) begin
    mem_rvalid_i <= 1'b0;
    if (pend != 0) begin
      if (lat_cnt == 0) begin
        mem_rvalid_i <= 1'b1;
        mem_rdata_i  <= ent(pend_a);
        pend = 0;
      end else lat_cnt--;
    end
    if (mem_req_o) begin
      chk(pend == 0, "R7", "read while outstanding", 64'(pend), 64'd0);
      if (rd_n < e_n)
        chk(mem_addr_o == e_addr[rd_n], "R3 R4", "entry address", 64'(mem_addr_o), 64'(e_addr[rd_n]));
      else
        chk(1'b0, "R2", "extra read", 64'(rd_n + 1), 64'(e_n));
      pend_a  = mem_addr_o;
      pend    = 1;
      lat_cnt = rd_n % 3;
      rd_n++;
    end
  end

  // mode 0: plain, 1: root changes mid-walk, 2: request pushed while busy
  task automatic do_walk(input logic [63:0] va, input logic [51:0] root, input int mode,
                         input string req);
    int cyc;
    predict(va, root);
    root_ptr_i = root;
    rd_n = 0;
    @(negedge clk_i);
    req_valid_i = 1'b1;
    req_vaddr_i = va;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    cyc = 0;
    while (!done_o) begin
      if (cyc == 3 && mode == 1) root_ptr_i = root ^ 52'h0_0F0F_0F0F_0000;
      if (cyc == 3 && mode == 2) begin
        chk(req_ready_o == 1'b0, "R8", "ready while busy", 64'(req_ready_o), 64'd0);
        req_valid_i = 1'b1;
        req_vaddr_i = 64'h0000_0000_1234_5000;
      end
      if (cyc == 4) req_valid_i = 1'b0;
      @(negedge clk_i);
      cyc++;
      if (cyc > 200) begin
        chk(1'b0, req, "walk timeout", 64'(cyc), 64'd0);
        return;
      end
    end
    req_valid_i = 1'b0;
    chk(fault_code_o == 2'(e_code), req, "fault code", 64'(fault_code_o), 64'(e_code));
    chk(fault_o == (e_code != 0), req, "fault flag", 64'(fault_o), 64'(e_code != 0));
    chk(rd_n == e_n, "R2", "read count", 64'(rd_n), 64'(e_n));
    if (e_code == 0) chk(paddr_o == e_pa, "R6", "paddr", 64'(paddr_o), 64'(e_pa));
    if (e_code == 1) chk(cyc == 0, "R1", "fault latency", 64'(cyc), 64'd0);
    if (e_code == 2) chk(fault_level_o == 2'(e_lvl), "R5", "fault level", 64'(fault_level_o), 64'(e_lvl));
    @(negedge clk_i);
    chk(done_o == 1'b0, "R9", "done width", 64'(done_o), 64'd0);
    if (mode == 2) begin
      repeat (4) @(negedge clk_i);
      chk(rd_n == e_n && req_ready_o, "R8", "busy request ignored", 64'(rd_n), 64'(e_n));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(req_ready_o == 1'b1, "R11", "reset ready", 64'(req_ready_o), 64'd1);
    chk(done_o == 1'b0, "R11", "reset done", 64'(done_o), 64'd0);
    chk(mem_req_o == 1'b0, "R11", "reset mem_req", 64'(mem_req_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // vector table: R1 R2 R3 R4 R6
    foreach (VECS[i]) begin
      do_walk(VECS[i].va, VECS[i].root, 0, "R1 R6");
      chk(e_code == int'(VECS[i].code), "R1", "table canon class", 64'(e_code), 64'(VECS[i].code));
    end

    // R5: missing entry at levels 0, 2, 3
    for (int l = 0; l < LV; l++) begin
      if (l == 1) continue;
      hole_on = 1'b0;
      predict(64'hFFFF_FABC_DEF0_1234, 52'h0_0003_3333_3000);
      hole_a  = e_addr[l];
      hole_on = 1'b1;
      do_walk(64'hFFFF_FABC_DEF0_1234, 52'h0_0003_3333_3000, 0, "R5");
    end
    hole_on = 1'b0;

    // R10: root change mid-walk, then new root used next
    do_walk(64'h0000_0456_789A_BCDE, 52'h0_0007_7770_0000, 1, "R10");
    do_walk(64'h0000_0456_789A_BCDE, 52'h0_0007_7770_0000 ^ 52'h0_0F0F_0F0F_0000, 0, "R10");

    // R8: request while busy is dropped
    do_walk(64'h0000_0321_0FED_C000, 52'h0_0002_0000_0000, 2, "R8");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule